// File: doc/BRIEF.md
# Inter-core mailbox bank with set/clear writes

The block holds a bank of 32-bit mailboxes, four per core across four cores, used by cores to signal each other. Software never writes a mailbox value directly. A write to a mailbox's set address ORs the data into it. A write to its clear address removes every bit that is 1 in the data. Each mailbox drives one interrupt level that stays high while the mailbox holds any nonzero bit. That level feeds a per-core interrupt router outside this block.

There are two independent single-cycle write ports. A set and a clear can therefore land on the same mailbox in one cycle. The read port is combinational: it returns a mailbox's current contents when addressed at either its set or its clear address.

Top module: `mbox_bank`

## Requirements
- R1: While reset is asserted and after it is released, every mailbox reads 0x00000000 and every bit of `irq_o` is low.
- R2: Mailbox m of core n is set at byte address 0x080 + 0x10*n + 4*m, and its interrupt is `irq_o[4*n+m]`.
- R3: A write to a set address ORs the written data into that mailbox on the next clock edge, leaving its other bits unchanged.
- R4: Mailbox m of core n is cleared at byte address 0x0C0 + 0x10*n + 4*m. A write there clears every bit that is 1 in the written data and leaves the rest unchanged.
- R5: `irq_o[4*n+m]` is high exactly when mailbox m of core n holds a nonzero value. It falls only in the cycle after a clear to that mailbox.
- R6: `rd_data_o` returns the current contents of the addressed mailbox when `rd_addr_i` is that mailbox's set or clear address. Any other read address returns zero.
- R7: When a clear and a set reach the same mailbox in the same cycle, the clear is applied first and the set second, so the bits being set end up 1.
- R8: A write whose address is unaligned (low two bits nonzero) or outside 0x080..0x0FF changes no mailbox. So does a port whose enable is low.
- R9: When both ports set the same mailbox in one cycle, the mailbox receives the OR of both data words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | NUM_WR | Per-port write enable |
| wr_addr_i | input | NUM_WR x ADDR_W | Per-port byte address |
| wr_data_i | input | NUM_WR x DATA_W | Per-port write data |
| rd_addr_i | input | ADDR_W | Read byte address |
| rd_data_o | output | DATA_W | Contents of the addressed mailbox, or zero |
| irq_o | output | NUM_MBOX | Per-mailbox nonzero level, index 4*core+mailbox |

## Verification
Directed patterns cover the following cases:
- Walking one-hot sets across all sixteen set addresses expose any swap of the core and mailbox index fields.
- Partial clears over a full mailbox separate a bitwise clear from a whole-word clear.
- Same-cycle set and clear on one mailbox through both ports fixes the order in which the two are applied. Two sets in one cycle show whether the data words merge or one is lost.
- Unaligned, below-range and above-range addresses, and disabled ports, show whether decoding is too loose.

A long run of random writes on both ports then compares every mailbox's interrupt level and the read data against a behavioural model on every clock.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  parameter int unsigned NUM_CORES     = 4;
  parameter int unsigned MBOX_PER_CORE = 4;
  parameter int unsigned DATA_W        = 32;
  parameter int unsigned ADDR_W        = 12;
  parameter int unsigned NUM_WR        = 2;
  parameter int unsigned SET_BASE      = 'h080;
  parameter int unsigned CLR_BASE      = 'h0C0;

  localparam int unsigned NUM_MBOX = NUM_CORES * MBOX_PER_CORE;
  localparam int unsigned IDX_W    = $clog2(NUM_MBOX);
  localparam int unsigned SPAN     = NUM_MBOX * 4;

  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/mbox_addr_dec.sv
module mbox_addr_dec #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NUM_MBOX = 16,
  parameter int unsigned SET_BASE = 'h080,
  parameter int unsigned CLR_BASE = 'h0C0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_MBOX-1:0] set_hit_o,
  output logic [NUM_MBOX-1:0] clr_hit_o
);
  localparam int unsigned SPAN = NUM_MBOX * 4;

  logic        aligned;
  logic        in_set, in_clr;
  logic [31:0] addr_w, set_off, clr_off;

  assign addr_w  = 32'(addr_i);
  assign aligned = (addr_i[1:0] == 2'b00);
  assign in_set  = (addr_w >= SET_BASE) && (addr_w < SET_BASE + SPAN);
  assign in_clr  = (addr_w >= CLR_BASE) && (addr_w < CLR_BASE + SPAN);
  assign set_off = (addr_w - SET_BASE) >> 2;
  assign clr_off = (addr_w - CLR_BASE) >> 2;

  for (genvar k = 0; k < NUM_MBOX; k++) begin : g_hit
    assign set_hit_o[k] = en_i && aligned && in_set && (set_off == 32'(k));
    assign clr_hit_o[k] = en_i && aligned && in_clr && (clr_off == 32'(k));
  end

  // R2
  set_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(set_hit_o));
  // R4
  set_clr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|set_hit_o) && (|clr_hit_o)));
  // R8
  idle_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (set_hit_o == '0 && clr_hit_o == '0));
endmodule

// File: rtl/mbox_cell.sv
module mbox_cell #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] q_o,
  output logic              irq_o
);
  // clear first, then set: bits set this cycle survive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_i) | set_i;
  end

  assign irq_o = |q_o;

  // R3
  set_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));
  // R4
  clr_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
  // R5
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(clr_i != '0));
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/mbox_rd_mux.sv
module mbox_rd_mux #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_MBOX = 16,
  parameter int unsigned SET_BASE = 'h080,
  parameter int unsigned CLR_BASE = 'h0C0
) (
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [NUM_MBOX-1:0][DATA_W-1:0] mbox_i,
  output logic [DATA_W-1:0]              data_o
);
  localparam int unsigned SPAN = NUM_MBOX * 4;

  logic [31:0] addr_w;
  assign addr_w = 32'(addr_i);

  always_comb begin
    data_o = '0;
    if (addr_i[1:0] == 2'b00) begin
      if (addr_w >= SET_BASE && addr_w < SET_BASE + SPAN)
        data_o = mbox_i[(addr_w - SET_BASE) >> 2];
      else if (addr_w >= CLR_BASE && addr_w < CLR_BASE + SPAN)
        data_o = mbox_i[(addr_w - CLR_BASE) >> 2];
    end
  end
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
  import mbox_pkg::*;
#(
  parameter int unsigned P_DATA_W   = mbox_pkg::DATA_W,
  parameter int unsigned P_ADDR_W   = mbox_pkg::ADDR_W,
  parameter int unsigned P_NUM_WR   = mbox_pkg::NUM_WR,
  parameter int unsigned P_NUM_MBOX = mbox_pkg::NUM_MBOX
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [P_NUM_WR-1:0]               wr_en_i,
  input  logic [P_NUM_WR-1:0][P_ADDR_W-1:0] wr_addr_i,
  input  logic [P_NUM_WR-1:0][P_DATA_W-1:0] wr_data_i,
  input  logic [P_ADDR_W-1:0]               rd_addr_i,
  output logic [P_DATA_W-1:0]               rd_data_o,
  output logic [P_NUM_MBOX-1:0]             irq_o
);
  logic [P_NUM_WR-1:0][P_NUM_MBOX-1:0]   set_hit, clr_hit;
  logic [P_NUM_MBOX-1:0][P_DATA_W-1:0]   set_bits, clr_bits, mbox_q;

  for (genvar p = 0; p < P_NUM_WR; p++) begin : g_port
    mbox_addr_dec #(
      .ADDR_W  (P_ADDR_W),
      .NUM_MBOX(P_NUM_MBOX),
      .SET_BASE(SET_BASE),
      .CLR_BASE(CLR_BASE)
    ) u_dec (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (wr_en_i[p]),
      .addr_i   (wr_addr_i[p]),
      .set_hit_o(set_hit[p]),
      .clr_hit_o(clr_hit[p])
    );
  end

  for (genvar k = 0; k < P_NUM_MBOX; k++) begin : g_mbox
    always_comb begin
      set_bits[k] = '0;
      clr_bits[k] = '0;
      for (int p = 0; p < P_NUM_WR; p++) begin
        if (set_hit[p][k]) set_bits[k] = set_bits[k] | wr_data_i[p];
        if (clr_hit[p][k]) clr_bits[k] = clr_bits[k] | wr_data_i[p];
      end
    end

    mbox_cell #(.DATA_W(P_DATA_W)) u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_bits[k]),
      .clr_i (clr_bits[k]),
      .q_o   (mbox_q[k]),
      .irq_o (irq_o[k])
    );
  end

  mbox_rd_mux #(
    .ADDR_W  (P_ADDR_W),
    .DATA_W  (P_DATA_W),
    .NUM_MBOX(P_NUM_MBOX),
    .SET_BASE(SET_BASE),
    .CLR_BASE(CLR_BASE)
  ) u_rd (
    .addr_i(rd_addr_i),
    .mbox_i(mbox_q),
    .data_o(rd_data_o)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (irq_o == '0));
  // R6
  rd_oob_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i < P_ADDR_W'(SET_BASE)) |-> (rd_data_o == '0));
endmodule

// File: tb/mbox_bank_tb_top.sv
module mbox_bank_tb_top;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        wr_en = '0;
  logic [1:0][11:0]  wr_addr = '0;
  logic [1:0][31:0]  wr_data = '0;
  logic [11:0]       rd_addr = '0;
  logic [31:0]       rd_data;
  logic [15:0]       irq;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [16];
  bit done = 0;

  always #10 clk = ~clk;

  mbox_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  // behavioural reference: returns mailbox index or -1
  function automatic int idx_of(input logic [11:0] a, input int base);
    int off;
    if (a[1:0] != 0) return -1;
    off = int'(a) - base;
    if (off < 0 || off >= 64) return -1;
    return off / 4;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) model[k] = '0;
    end else begin
      logic [31:0] s [16];
      logic [31:0] c [16];
      for (int k = 0; k < 16; k++) begin s[k] = '0; c[k] = '0; end
      for (int p = 0; p < 2; p++) if (wr_en[p]) begin
        int i;
        i = idx_of(wr_addr[p], 'h080);
        if (i >= 0) s[i] |= wr_data[p];
        i = idx_of(wr_addr[p], 'h0C0);
        if (i >= 0) c[i] |= wr_data[p];
      end
      for (int k = 0; k < 16; k++) model[k] = (model[k] & ~c[k]) | s[k];
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    int i;
    i = idx_of(a, 'h080);
    if (i < 0) i = idx_of(a, 'h0C0);
    return (i < 0) ? 32'h0 : model[i];
  endfunction

  // per-cycle comparison against the model (R5 irq, R6 read)
  always @(negedge clk) if (rst_n && !done) begin
    logic [15:0] ei;
    for (int k = 0; k < 16; k++) ei[k] = (model[k] != 0);
    check(irq == ei, "R5", 32'(irq), 32'(ei));
    check(rd_data == exp_rd(rd_addr), "R6", rd_data, exp_rd(rd_addr));
  end

  task automatic wr(input int p, input logic [11:0] a, input logic [31:0] d);
    wr_en[p] = 1'b1; wr_addr[p] = a; wr_data[p] = d;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    wr_en = '0;
  endtask

  task automatic peek(input logic [11:0] a, input logic [31:0] exp, input string req);
    rd_addr = a; #1;
    check(rd_data == exp, req, rd_data, exp);
  endtask

  initial begin
    #100000000;
    fails++; checks++;
    $display("FAIL watchdog act=0 exp=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #5;
    // R1: reset state
    check(irq == 16'h0, "R1", 32'(irq), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 16; k++) peek(12'h080 + 12'(4*k), 0, "R1");
    check(irq == 16'h0, "R1", 32'(irq), 0);

    // R2/R3: walking one-hot sets, each mailbox gets its own pattern
    for (int n = 0; n < 4; n++)
      for (int m = 0; m < 4; m++) begin
        wr(0, 12'h080 + 12'(16*n + 4*m), 32'h1 << (4*n + m));
        step();
        check(irq[4*n+m] == 1'b1, "R2", 32'(irq), 32'(1 << (4*n+m)));
      end
    for (int k = 0; k < 16; k++) peek(12'h080 + 12'(4*k), 32'h1 << k, "R2");
    wr(1, 12'h094, 32'hF0F0_0000); step();
    peek(12'h094, 32'hF0F0_0020, "R3");

    // R4: partial clear, then full clear
    wr(0, 12'h0D4, 32'h00F0_0020); step();
    peek(12'h0D4, 32'hF000_0000, "R4");
    check(irq[5] == 1'b1, "R4", 32'(irq[5]), 1);
    wr(0, 12'h0D4, 32'hFFFF_FFFF); step();
    peek(12'h094, 32'h0, "R4");
    check(irq[5] == 1'b0, "R5", 32'(irq[5]), 0);

    // R7: clear and set on one mailbox in the same cycle
    wr(0, 12'h0BC, 32'h0000_00FF); step();
    wr(0, 12'h0FC, 32'h0000_FFFF);
    wr(1, 12'h0BC, 32'h0000_0F00); step();
    peek(12'h0FC, 32'h0000_0F00, "R7");

    // R9: two sets in one cycle
    wr(0, 12'h0A0, 32'hA000_0000);
    wr(1, 12'h0A0, 32'h0500_0000); step();
    peek(12'h0A0, 32'hA500_0100, "R9");

    // R8: unaligned, out of range and disabled writes
    wr(0, 12'h081, 32'hFFFF_FFFF);
    wr(1, 12'h07C, 32'hFFFF_FFFF); step();
    wr(0, 12'h100, 32'hFFFF_FFFF);
    wr(1, 12'h0C2, 32'hFFFF_FFFF); step();
    wr_en = '0; wr_addr[0] = 12'h084; wr_data[0] = 32'hFFFF_FFFF; step();
    peek(12'h080, 32'h1, "R8");
    peek(12'h084, 32'h2, "R8");
    peek(12'h0C0, 32'h1, "R8");
    peek(12'h100, 32'h0, "R6");
    peek(12'h082, 32'h0, "R6");

    // random traffic, model compared every clock
    for (int t = 0; t < 4000; t++) begin
      for (int p = 0; p < 2; p++) begin
        wr_en[p]   = 1'($urandom_range(0, 3) != 0);
        wr_addr[p] = 12'($urandom_range(0, 'h13F));
        if ($urandom_range(0, 3) != 0) wr_addr[p][1:0] = 2'b00;
        wr_data[p] = $urandom;
        if ($urandom_range(0, 1) == 1) wr_data[p] &= $urandom;
      end
      rd_addr = 12'($urandom_range('h07C, 'h103));
      @(posedge clk); @(negedge clk);
    end
    wr_en = '0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule